// File: doc/BRIEF.md
# Serial Port Power-Mode and Wake Controller

This block holds an 8N1 serial transmitter and receiver together with the control that decides what they do when the system goes to low power. A sleep request stops both engines and returns them to their rest state. Any frame that is only partly sent is cut short, with the line returned high, and any frame that is only partly received is thrown away. The divisor input, the last received byte and the engine configuration keep their values. An idle request halts the engines only when the stop-in-idle bit is set. A halted engine keeps its exact position inside the frame and carries on from there when idle ends.

While asleep, the block can watch the receive line for a falling edge, which is the start of an incoming character. When wake is enabled and the module is enabled, that edge raises the receive interrupt. This interrupt does not depend on any per-character threshold. It stays up until sleep is released. A wake request to the system is raised only when the receive interrupt enable is also set. The edge detector runs from the always-on clock, so it keeps working while the bit-timing counters are held at zero.

The bit time is `baud_div_i` clock cycles, and it must be at least 4. The receiver checks the start bit halfway through the bit and samples each data bit in the middle of that bit.

Top module: `uart_pm_ctrl`

## Requirements
- R1: After `tx_start_i` is accepted at a clock edge, `tx_o` carries, from that edge on, a low start bit, then 8 data bits least significant first, then a high stop bit. Each bit lasts exactly `baud_div_i` cycles. `tx_busy_o` is high for the 10*`baud_div_i` cycles of the frame. `tx_o` is high whenever no frame is in progress.
- R2: A frame on `rx_i` that starts with a falling edge, has a low start bit at mid-bit and has a high stop bit gives a one-cycle `rx_valid_o` pulse. In that same cycle `rx_data_o` holds the 8 data bits, with the first received bit at bit 0.
- R3: When `sleep_i` is sampled high during a transmission, `tx_o` is high and `tx_busy_o` is low from the next cycle on. The aborted frame does not resume after sleep ends.
- R4: When `sleep_i` is sampled high during a reception, no `rx_valid_o` follows for that frame. After sleep ends, the receiver starts again only on a new falling edge.
- R5: `rx_data_o` keeps its value through sleep and through idle. It changes only together with an `rx_valid_o` pulse.
- R6: With `idle_i` and `stop_idle_i` both high, both engines freeze, and `tx_o` holds its level. When idle ends, the frame continues from the same point. With `stop_idle_i` low, idle has no effect.
- R7: During sleep, with `wake_en_i` and `en_i` both high, a falling edge on `rx_i` raises `rx_irq_o` two clock edges after the low level is first sampled. `rx_irq_o` stays high until the first edge that samples `sleep_i` low. At that edge the flag clears, and clearing takes priority over a new edge arriving in the same cycle.
- R8: `wake_o` is high only while the wake flag of R7 is set and `rxie_i` is high. No flag is raised if `wake_en_i` or `en_i` is low. Outside sleep, `rx_irq_o` equals `rx_valid_o`.
- R9: `tx_start_i` is ignored while a frame is in progress, while sleeping, while halted in idle, or while disabled. A sleep request in the same cycle as a start request prevents the start.
- R10: Setting `en_i` low aborts both engines in the same way as sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable |
| sleep_i | input | 1 | Sleep request |
| idle_i | input | 1 | Idle request |
| stop_idle_i | input | 1 | 1: halt the engines in idle |
| wake_en_i | input | 1 | Arm wake-on-start-edge during sleep |
| rxie_i | input | 1 | Receive interrupt enable |
| baud_div_i | input | DIV_W | Clock cycles per bit (at least 4) |
| tx_start_i | input | 1 | Request to send `tx_data_i` |
| tx_data_i | input | DATA_W | Byte to send |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| tx_busy_o | output | 1 | Frame in progress |
| rx_valid_o | output | 1 | Received byte pulse |
| rx_data_o | output | DATA_W | Last received byte |
| rx_irq_o | output | 1 | Receive interrupt |
| wake_o | output | 1 | Wake request to the system |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a sleep request and a transmit start. The bench raises `sleep_i` and `tx_start_i` in the same cycle and expects the line to stay high with busy low, because abort takes priority. The second pair is a wake edge and the sleep release. The bench drops `rx_i` so that the flag would be set exactly on the edge that first samples `sleep_i` low. It expects no interrupt, and it raises the line in time so that the receiver rejects the false start. A per-cycle behavioural model of the line, the busy flag and the wake flag judges both cases.

// File: rtl/uart_pm_pkg.sv
package uart_pm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } frame_st_e;
endpackage

// File: rtl/pm_baud_cnt.sv
module pm_baud_cnt #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [DIV_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (adv_i)  cnt_o <= cnt_o + DIV_W'(1);
  end
endmodule

// File: rtl/pm_wake.sv
module pm_wake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic sleep_i,
  input  logic wake_en_i,
  input  logic en_i,
  output logic rx_s_o,
  output logic fall_o,
  output logic flag_o
);
  logic s1_q, s2_q, prev_q;

  // always-on domain: keeps sampling while the bit counters are held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= rx_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rx_s_o = s2_q;
  assign fall_o = prev_q & ~s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  flag_o <= 1'b0;
    else if (!sleep_i)                            flag_o <= 1'b0;
    else if (wake_en_i && en_i && fall_o)         flag_o <= 1'b1;
  end

  AST_WAKE_CLR_ON_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |=> !flag_o); // R7
  AST_WAKE_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(wake_en_i && en_i && sleep_i)); // R8
endmodule

// File: rtl/pm_tx.sv
module pm_tx
  import uart_pm_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              run_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              tx_o,
  output logic              busy_o
);
  localparam int IDX_W = $clog2(DATA_W);

  frame_st_e         st_q;
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DIV_W-1:0]  cnt;
  logic              wrap;

  assign wrap = (cnt == div_i - DIV_W'(1));

  pm_baud_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (abort_i | (st_q == ST_IDLE) | (run_i & wrap)),
    .adv_i  (run_i & (st_q != ST_IDLE)),
    .cnt_o  (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sh_q  <= '0;
      idx_q <= '0;
    end else if (abort_i) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else if (run_i) begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_START;
          sh_q  <= data_i;
          idx_q <= '0;
        end
        ST_START: if (wrap) st_q <= ST_DATA;
        ST_DATA: if (wrap) begin
          sh_q  <= sh_q >> 1;
          idx_q <= idx_q + IDX_W'(1);
          if (idx_q == IDX_W'(DATA_W - 1)) st_q <= ST_STOP;
        end
        ST_STOP: if (wrap) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = sh_q[0];
      default:  tx_o = 1'b1;
    endcase
  end
  assign busy_o = (st_q != ST_IDLE);

  AST_TX_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (tx_o && !busy_o)); // R3
  AST_TX_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!abort_i && !run_i) |=> $stable(tx_o)); // R6
  AST_TX_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(run_i && start_i)) |=> !busy_o); // R9
endmodule

// File: rtl/pm_rx.sv
module pm_rx
  import uart_pm_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              run_i,
  input  logic              rx_s_i,
  input  logic              fall_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int IDX_W = $clog2(DATA_W);

  frame_st_e         st_q;
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DIV_W-1:0]  cnt;
  logic              wrap, mid, clr;

  assign wrap = (cnt == div_i - DIV_W'(1));
  assign mid  = (cnt == (div_i >> 1) - DIV_W'(1));
  assign clr  = abort_i | (st_q == ST_IDLE)
              | (run_i & ((st_q == ST_START) ? mid : wrap));

  pm_baud_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (run_i & (st_q != ST_IDLE)),
    .cnt_o  (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (abort_i) begin
        st_q  <= ST_IDLE;
        idx_q <= '0;
      end else if (run_i) begin
        unique case (st_q)
          ST_IDLE: if (fall_i) st_q <= ST_START;
          ST_START: if (mid) begin
            st_q  <= rx_s_i ? ST_IDLE : ST_DATA;
            idx_q <= '0;
          end
          ST_DATA: if (wrap) begin
            sh_q  <= {rx_s_i, sh_q[DATA_W-1:1]};
            idx_q <= idx_q + IDX_W'(1);
            if (idx_q == IDX_W'(DATA_W - 1)) st_q <= ST_STOP;
          end
          ST_STOP: if (wrap) begin
            st_q <= ST_IDLE;
            if (rx_s_i) begin
              valid_o <= 1'b1;
              data_o  <= sh_q;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  AST_RX_ABORT_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !valid_o); // R4
  AST_RX_DATA_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o)); // R5
  AST_RX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R2
endmodule

// File: rtl/uart_pm_ctrl.sv
module uart_pm_ctrl #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sleep_i,
  input  logic              idle_i,
  input  logic              stop_idle_i,
  input  logic              wake_en_i,
  input  logic              rxie_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic              tx_start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_i,
  output logic              tx_o,
  output logic              tx_busy_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_irq_o,
  output logic              wake_o
);
  logic abort, run, rx_s, fall, wake_flag;

  assign abort = sleep_i | ~en_i;                       // R10
  assign run   = ~abort & ~(idle_i & stop_idle_i);

  pm_wake u_wake (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_i      (rx_i),
    .sleep_i   (sleep_i),
    .wake_en_i (wake_en_i),
    .en_i      (en_i),
    .rx_s_o    (rx_s),
    .fall_o    (fall),
    .flag_o    (wake_flag)
  );

  pm_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (abort),
    .run_i   (run),
    .start_i (tx_start_i),
    .data_i  (tx_data_i),
    .div_i   (baud_div_i),
    .tx_o    (tx_o),
    .busy_o  (tx_busy_o)
  );

  pm_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (abort),
    .run_i   (run),
    .rx_s_i  (rx_s),
    .fall_i  (fall),
    .div_i   (baud_div_i),
    .valid_o (rx_valid_o),
    .data_o  (rx_data_o)
  );

  // wake edge bypasses any per-character threshold
  assign rx_irq_o = rx_valid_o | wake_flag;
  assign wake_o   = wake_flag & rxie_i;

  AST_SLEEP_NO_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !rx_valid_o); // R4
  AST_WAKE_ONLY_IN_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !sleep_i) |=> !wake_o); // R8
endmodule

// File: tb/sim_uart_pm_ctrl.sv
module sim_uart_pm_ctrl;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, sleep = 1'b0, idle = 1'b0, stop_idle = 1'b0;
  logic wake_en = 1'b0, rxie = 1'b0, tx_start = 1'b0, rx = 1'b1;
  logic [7:0] tx_data = '0;
  logic tx_o, busy, rx_valid, rx_irq, wake;
  logic [7:0] rx_data;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_pos = -1;
  logic [7:0] m_d = '0;
  logic m_flag = 1'b0;
  logic h1 = 1'b1, h2 = 1'b1, h3 = 1'b1;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  uart_pm_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sleep_i(sleep), .idle_i(idle),
    .stop_idle_i(stop_idle), .wake_en_i(wake_en), .rxie_i(rxie),
    .baud_div_i(8'(DIV)), .tx_start_i(tx_start), .tx_data_i(tx_data), .rx_i(rx),
    .tx_o(tx_o), .tx_busy_o(busy), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .rx_irq_o(rx_irq), .wake_o(wake)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic exp_line(int pos, logic [7:0] d);
    int b;
    if (pos < 0) return 1'b1;
    b = pos / DIV;
    if (b == 0) return 1'b0;
    if (b <= 8) return d[b-1];
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = -1; m_flag = 0; h1 = 1; h2 = 1; h3 = 1;
    end else begin
      // transmitter
      if (!en || sleep) m_pos = -1;
      else if (m_pos < 0) begin
        if (!(idle && stop_idle) && tx_start) begin m_pos = 0; m_d = tx_data; end
      end else if (!(idle && stop_idle)) begin
        m_pos++;
        if (m_pos == 10 * DIV) m_pos = -1;
      end
      // wake flag
      if (!sleep) m_flag = 0;
      else if (wake_en && en && h3 && !h2) m_flag = 1;
      h3 = h2; h2 = h1; h1 = rx;
      #3;
      chk(tx_o == exp_line(m_pos, m_d), cur_req, "tx_o", tx_o, exp_line(m_pos, m_d));
      chk(busy == (m_pos >= 0), cur_req, "busy", busy, m_pos >= 0);
      chk(rx_irq == (m_flag | rx_valid), "R7", "rx_irq", rx_irq, m_flag | rx_valid);
      chk(wake == (m_flag & rxie), "R8", "wake", wake, m_flag & rxie);
      if (rx_valid) begin
        if (exp_q.size() == 0) chk(0, "R4", "unexpected rx byte", rx_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R2", "rx_data", rx_data, e);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_tx(input logic [7:0] d);
    @(negedge clk); tx_start = 1; tx_data = d;
    @(negedge clk); tx_start = 0;
  endtask

  task automatic send_rx(input logic [7:0] d, input bit expect_it);
    if (expect_it) exp_q.push_back(d);
    for (int i = 0; i < 10; i++) begin
      rx = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : d[i-1];
      cyc(DIV);
    end
    rx = 1;
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    cyc(3); rst_n = 1;
    cyc(1);
    chk(tx_o == 1 && !busy && !rx_valid && !rx_irq && !wake, "R1", "reset state",
        {tx_o, busy, rx_valid, rx_irq, wake}, 5'b10000);

    // R1 frame; R9 start ignored while busy
    cur_req = "R1"; send_tx(8'hA5); cyc(10);
    cur_req = "R9"; send_tx(8'h3E); cyc(40);

    // R2 receive
    send_rx(8'h3C, 1); cyc(6);
    send_rx(8'hC3, 1); cyc(6);
    chk(rx_data == 8'hC3, "R2", "last byte", rx_data, 8'hC3);

    // R3 sleep aborts tx
    cur_req = "R3"; send_tx(8'h00); cyc(15);
    sleep = 1; cyc(8); sleep = 0; cyc(50);
    chk(tx_o == 1 && !busy, "R3", "line after abort", tx_o, 1);

    // R9 sleep and start in the same cycle
    cur_req = "R9";
    @(negedge clk); sleep = 1; tx_start = 1; tx_data = 8'h55;
    @(negedge clk); sleep = 0; tx_start = 0;
    cyc(2);
    chk(!busy && tx_o, "R9", "start blocked by sleep", busy, 0);

    // R6 idle halt and continue
    cur_req = "R6"; send_tx(8'h5A); cyc(10);
    idle = 1; stop_idle = 1; cyc(12); idle = 0; cyc(45);
    stop_idle = 0; idle = 1; send_tx(8'h96); cyc(45); idle = 0;

    // R10 disable aborts
    cur_req = "R10"; send_tx(8'h0F); cyc(12);
    en = 0; cyc(3); en = 1; cyc(45);

    // R5 retention
    cur_req = "R5"; held = rx_data;
    sleep = 1; cyc(20); sleep = 0; cyc(2);
    chk(rx_data == held, "R5", "data after sleep", rx_data, held);
    idle = 1; stop_idle = 1; cyc(20); idle = 0; stop_idle = 0; cyc(2);
    chk(rx_data == held, "R5", "data after idle", rx_data, held);

    // R4 sleep aborts rx; partial frame dropped
    cur_req = "R4";
    fork
      send_rx(8'h00, 0);
      begin cyc(18); sleep = 1; cyc(6); sleep = 0; end
    join
    cyc(10);
    chk(rx_data == held, "R4", "partial frame dropped", rx_data, held);
    send_rx(8'h81, 1); cyc(8);
    chk(rx_data == 8'h81, "R4", "fresh frame after exit", rx_data, 8'h81);

    // R7/R8 wake matrix
    cur_req = "R7"; en = 1; wake_en = 1; rxie = 1;
    sleep = 1; cyc(3); rx = 0; cyc(4); rx = 1; cyc(3);
    chk(rx_irq == 1, "R7", "wake irq", rx_irq, 1);
    chk(wake == 1, "R8", "wake request", wake, 1);
    sleep = 0; cyc(2);
    chk(rx_irq == 0, "R7", "cleared on exit", rx_irq, 0);

    rxie = 0; sleep = 1; cyc(3); rx = 0; cyc(4); rx = 1; cyc(3);
    chk(rx_irq == 1 && wake == 0, "R8", "irq without enable", {rx_irq, wake}, 2'b10);
    sleep = 0; cyc(2);

    rxie = 1; wake_en = 0; sleep = 1; cyc(3); rx = 0; cyc(4); rx = 1; cyc(3);
    chk(rx_irq == 0 && wake == 0, "R8", "wake disarmed", {rx_irq, wake}, 0);
    sleep = 0; cyc(2);

    wake_en = 1; en = 0; sleep = 1; cyc(3); rx = 0; cyc(4); rx = 1; cyc(3);
    chk(rx_irq == 0 && wake == 0, "R8", "module disabled", {rx_irq, wake}, 0);
    sleep = 0; en = 1; cyc(4);

    // R7 edge lands on the sleep release edge: clear wins
    sleep = 1; cyc(3); rx = 0; cyc(2); sleep = 0; rx = 1; cyc(3);
    chk(rx_irq == 0 && wake == 0, "R7", "release beats edge", {rx_irq, wake}, 0);
    cyc(50);

    chk(exp_q.size() == 0, "R2", "bytes outstanding", exp_q.size(), 0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule